// File: doc/BRIEF.md
# Voltage-frequency scaling sequencer

This controller moves a processor between performance levels. Each level stands for an operating point: a supply voltage code for an external regulator and a frequency code for an external clock synthesizer. Software asks for a new level with a one-cycle load-change event. The sequencer then walks the regulator and the synthesizer to the new operating point. The order of the two changes is chosen so that the voltage is always high enough for the clock in use.

When speeding up, the voltage code ramps up one step per dwell interval, and the sequencer waits for the regulator's settled flag. Only then does it issue the faster frequency code. When slowing down, the slower frequency code goes out first. The voltage ramps down only after the synthesizer has locked again. The CPU stall output covers only the relock window.

If the regulator or the synthesizer does not respond within a programmable number of cycles, the sequencer sets a sticky error flag. It then puts both codes back to those of the last level reached. A request that arrives while a transition runs is held, and the newest one is served when the sequencer is idle again.

Top module: `dvfs_sequencer`

## Requirements
- R1: After reset, current level is 0, voltage code is 0, frequency code is 0, and stall, busy and error are all low.
- R2: Level n maps to frequency code n and voltage code 2·n (VBASE=0, VSTEP=2); after a completed move to n, both code outputs hold these values.
- R3: On a move to a higher level, the voltage code reaches the target's value and the settled flag is seen before the frequency code changes.
- R4: On a move to a lower level, the frequency code changes first, and the voltage code starts to fall only after the lock flag is seen.
- R5: Stall rises in the cycle the new frequency code appears and falls in the cycle after the lock flag is first sampled high. Stall is low in every cycle in which the voltage code changes. The frequency code never changes without stall, except on a timeout revert.
- R6: The voltage code moves by exactly one per step, and steps within one transition are dwell_cycles_i cycles apart.
- R7: If settled or lock is not seen within timeout_cycles_i cycles, the error flag sets and stays set until reset. Both codes return to those of the current level, stall drops, busy drops, and the level is unchanged.
- R8: A request made during a transition does not disturb it. The newest such request is held and is carried out after the running transition completes.
- R9: A request for the level already current leaves both codes unchanged, and busy and stall stay low.
- R10: Busy is high from the cycle after a request is taken until the transition ends. The current-level output changes only in the cycle busy falls.
- R11: While no error is flagged, the voltage code never falls below 2·(frequency code), the voltage for the frequency in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load-change event: one-cycle request for a new level |
| req_level_i | input | 4 | Requested level |
| dwell_cycles_i | input | 16 | Cycles between voltage steps |
| timeout_cycles_i | input | 16 | Cycles allowed for settled or lock |
| vreg_settled_i | input | 1 | Regulator output settled |
| pll_lock_i | input | 1 | Clock synthesizer locked |
| vcode_o | output | 5 | Voltage code to the regulator |
| fcode_o | output | 4 | Frequency code to the synthesizer |
| cpu_stall_o | output | 1 | CPU stall during relock |
| busy_o | output | 1 | Transition in progress |
| level_o | output | 4 | Last level reached |
| error_o | output | 1 | Sticky timeout flag |

## Verification
The main function is tried on every ordered pair of the 16 levels, so the sweep covers upward and downward moves of every size as well as zero-size moves. Upward moves separate the voltage-first order from the frequency-first order, and the step spacing from the final settle wait. Bursts of requests during a long ramp show whether the held request is the newest one and whether it waits for idle. A regulator and a synthesizer that never respond show the timeout path and the revert of each code.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_VRAMP,
    ST_VSETTLE,
    ST_RELOCK
  } seq_state_e;
endpackage

// File: rtl/dvfs_op_table.sv
module dvfs_op_table #(
  parameter int LEVELS  = 16,
  parameter int LVL_W   = 4,
  parameter int VCODE_W = 5,
  parameter int FCODE_W = 4,
  parameter int VBASE   = 0,
  parameter int VSTEP   = 2
) (
  input  logic [LVL_W-1:0]   level_i,
  output logic [VCODE_W-1:0] vcode_o,
  output logic [FCODE_W-1:0] fcode_o
);
  logic [VCODE_W-1:0] v_tab [LEVELS];
  logic [FCODE_W-1:0] f_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_ent
    assign v_tab[g] = VCODE_W'(VBASE + VSTEP * g);
    assign f_tab[g] = FCODE_W'(g);
  end

  assign vcode_o = v_tab[level_i];
  assign fcode_o = f_tab[level_i];
endmodule

// File: rtl/dvfs_cycle_timer.sv
module dvfs_cycle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign hit_o   = en_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= hit_o ? '0 : cnt_nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/dvfs_req_latch.sv
module dvfs_req_latch #(
  parameter int LVL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic             take_i,
  output logic             pend_valid_o,
  output logic [LVL_W-1:0] pend_level_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid_o <= 1'b0;
      pend_level_o <= '0;
    end else if (req_valid_i) begin
      pend_valid_o <= 1'b1;
      pend_level_o <= req_level_i;
    end else if (take_i) begin
      pend_valid_o <= 1'b0;
    end
  end

  // newest request always wins over an older held one
  assert_hold_newest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (pend_valid_o && pend_level_o == $past(req_level_i)));
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer #(
  parameter int LEVELS  = 16,
  parameter int VCODE_W = 5,
  parameter int FCODE_W = 4,
  parameter int VBASE   = 0,
  parameter int VSTEP   = 2,
  parameter int CNT_W   = 16,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LVL_W-1:0]   req_level_i,
  input  logic [CNT_W-1:0]   dwell_cycles_i,
  input  logic [CNT_W-1:0]   timeout_cycles_i,
  input  logic               vreg_settled_i,
  input  logic               pll_lock_i,
  output logic [VCODE_W-1:0] vcode_o,
  output logic [FCODE_W-1:0] fcode_o,
  output logic               cpu_stall_o,
  output logic               busy_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               error_o
);
  import dvfs_pkg::*;

  seq_state_e         state_q, state_d;
  logic [LVL_W-1:0]   tgt_q, tgt_d, level_q, level_d;
  logic               up_q, up_d, stall_q, stall_d, err_q, err_d;
  logic [VCODE_W-1:0] vcode_q, vcode_d;
  logic [FCODE_W-1:0] fcode_q, fcode_d;
  logic               pend_valid, take, hit, fault;
  logic [LVL_W-1:0]   pend_level, tab_sel;
  logic [VCODE_W-1:0] tab_v, cur_v;
  logic [FCODE_W-1:0] tab_f, cur_f;
  logic [CNT_W-1:0]   limit;

  dvfs_req_latch #(.LVL_W(LVL_W)) u_req (
    .clk_i, .rst_ni,
    .req_valid_i, .req_level_i,
    .take_i       (take),
    .pend_valid_o (pend_valid),
    .pend_level_o (pend_level)
  );

  assign tab_sel = (state_q == ST_IDLE) ? pend_level : tgt_q;

  dvfs_op_table #(.LEVELS(LEVELS), .LVL_W(LVL_W), .VCODE_W(VCODE_W),
                  .FCODE_W(FCODE_W), .VBASE(VBASE), .VSTEP(VSTEP)) u_tab_tgt (
    .level_i (tab_sel), .vcode_o (tab_v), .fcode_o (tab_f)
  );

  // operating point of the last level reached, used for timeout revert
  dvfs_op_table #(.LEVELS(LEVELS), .LVL_W(LVL_W), .VCODE_W(VCODE_W),
                  .FCODE_W(FCODE_W), .VBASE(VBASE), .VSTEP(VSTEP)) u_tab_cur (
    .level_i (level_q), .vcode_o (cur_v), .fcode_o (cur_f)
  );

  assign limit = (state_q == ST_VRAMP) ? dwell_cycles_i : timeout_cycles_i;

  dvfs_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .clear_i (state_d != state_q),
    .en_i    (state_q != ST_IDLE),
    .limit_i (limit),
    .hit_o   (hit)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    up_d    = up_q;
    vcode_d = vcode_q;
    fcode_d = fcode_q;
    stall_d = stall_q;
    level_d = level_q;
    err_d   = err_q;
    take    = 1'b0;
    fault   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_valid) begin
          take  = 1'b1;
          tgt_d = pend_level;
          if (pend_level > level_q) begin
            up_d    = 1'b1;
            state_d = ST_VRAMP;
          end else if (pend_level < level_q) begin
            up_d    = 1'b0;
            fcode_d = tab_f;
            stall_d = 1'b1;
            state_d = ST_RELOCK;
          end
        end
      end
      ST_VRAMP: begin
        if (vcode_q == tab_v) state_d = ST_VSETTLE;
        else if (hit)         vcode_d = up_q ? vcode_q + 1'b1 : vcode_q - 1'b1;
      end
      ST_VSETTLE: begin
        if (vreg_settled_i) begin
          if (up_q) begin
            fcode_d = tab_f;
            stall_d = 1'b1;
            state_d = ST_RELOCK;
          end else begin
            level_d = tgt_q;
            state_d = ST_IDLE;
          end
        end else if (hit) begin
          fault = 1'b1;
        end
      end
      ST_RELOCK: begin
        if (pll_lock_i) begin
          stall_d = 1'b0;
          if (up_q) begin
            level_d = tgt_q;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_VRAMP;
          end
        end else if (hit) begin
          fault = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fault) begin
      err_d   = 1'b1;
      vcode_d = cur_v;
      fcode_d = cur_f;
      stall_d = 1'b0;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      up_q    <= 1'b0;
      vcode_q <= VCODE_W'(VBASE);
      fcode_q <= '0;
      stall_q <= 1'b0;
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      up_q    <= up_d;
      vcode_q <= vcode_d;
      fcode_q <= fcode_d;
      stall_q <= stall_d;
      level_q <= level_d;
      err_q   <= err_d;
    end
  end

  assign vcode_o     = vcode_q;
  assign fcode_o     = fcode_q;
  assign cpu_stall_o = stall_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign level_o     = level_q;
  assign error_o     = err_q;

  logic past_valid_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  assert_v_covers_f_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !error_o |-> (int'(vcode_o) >= VBASE + VSTEP * int'(fcode_o)));

  assert_single_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && !error_o && vcode_o != $past(vcode_o)) |->
      (vcode_o == $past(vcode_o) + 1'b1 || vcode_o == $past(vcode_o) - 1'b1));

  assert_no_stall_on_vstep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && !error_o && vcode_o != $past(vcode_o)) |-> !cpu_stall_o);

  assert_fcode_under_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && !error_o && fcode_o != $past(fcode_o)) |-> cpu_stall_o);

  assert_error_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && $past(error_o)) |-> error_o);

  assert_stall_in_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> busy_o);

  assert_level_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && level_o != $past(level_o)) |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/dvfs_sequencer_tb_top.sv
`timescale 1ns/1ps
module dvfs_sequencer_tb_top;
  localparam int DWELL  = 2;
  localparam int TMO    = 20;
  localparam int PLL_D  = 3;
  localparam int REG_D  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_level = '0;
  logic        settled, lock;
  logic [4:0]  vcode_o;
  logic [3:0]  fcode_o, level_o;
  logic        cpu_stall_o, busy_o, error_o;
  logic        reg_stuck = 1'b0, pll_stuck = 1'b0;

  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  dvfs_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_level_i(req_level),
    .dwell_cycles_i(16'(DWELL)), .timeout_cycles_i(16'(TMO)),
    .vreg_settled_i(settled), .pll_lock_i(lock),
    .vcode_o, .fcode_o, .cpu_stall_o, .busy_o, .level_o, .error_o
  );

  // regulator and clock synthesizer models: flag drops on a code change, returns after a delay
  logic [4:0] last_v; int vcnt;
  logic [3:0] last_f; int fcnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_v <= '0; vcnt <= 0; last_f <= '0; fcnt <= 0;
    end else begin
      if (vcode_o != last_v) begin last_v <= vcode_o; vcnt <= REG_D; end
      else if (vcnt != 0) vcnt <= vcnt - 1;
      if (fcode_o != last_f) begin last_f <= fcode_o; fcnt <= PLL_D; end
      else if (fcnt != 0) fcnt <= fcnt - 1;
    end
  end
  assign settled = (vcode_o == last_v) && (vcnt == 0) && !reg_stuck;
  assign lock    = (fcode_o == last_f) && (fcnt == 0) && !pll_stuck;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // continuous ordering / stall / ramp monitor
  int pv = 0, pf = 0, scnt = 0, xid = 0, vx = -1, vcyc = 0;
  bit pstall = 0, pbusy = 0;
  always @(negedge clk) begin
    if (rst_n && !error_o) begin
      if (busy_o && !pbusy) xid++;
      if (int'(vcode_o) != pv) begin
        chk(int'(vcode_o) == pv + 1 || int'(vcode_o) + 1 == pv, "R6 step size", vcode_o, pv);
        chk(!cpu_stall_o, "R5 stall low on voltage step", cpu_stall_o, 0);
        if (vx == xid) chk(cyc - vcyc == DWELL, "R6 dwell spacing", cyc - vcyc, DWELL);
        if (int'(vcode_o) < pv)
          chk(2 * int'(fcode_o) <= int'(vcode_o), "R4 freq lowered first", fcode_o, vcode_o / 2);
        vx = xid; vcyc = cyc;
      end
      if (int'(fcode_o) != pf) begin
        chk(cpu_stall_o, "R5 stall with new freq code", cpu_stall_o, 1);
        if (int'(fcode_o) > pf)
          chk(int'(vcode_o) == 2 * int'(fcode_o), "R3 voltage raised first", vcode_o, 2 * fcode_o);
      end
      if (cpu_stall_o) scnt++;
      else if (pstall) begin
        chk(scnt == PLL_D + 2, "R5 stall length", scnt, PLL_D + 2);
        scnt = 0;
      end
    end
    pv = int'(vcode_o); pf = int'(fcode_o); pstall = cpu_stall_o; pbusy = busy_o;
  end

  task automatic pulse(input int lvl);
    @(negedge clk); req_valid = 1'b1; req_level = 4'(lvl);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic move(input int lvl);
    pulse(lvl);
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(vcode_o == 0 && fcode_o == 0, "R1 codes in reset", vcode_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level_o == 0, "R1 level", level_o, 0);
    chk(!cpu_stall_o && !busy_o && !error_o, "R1 flags", {cpu_stall_o, busy_o, error_o}, 0);

    // all ordered level pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        move(a);
        move(b);
        chk(level_o == 4'(b), "R10 level after move", level_o, b);
        chk(vcode_o == 5'(2 * b), "R2 voltage code", vcode_o, 2 * b);
        chk(fcode_o == 4'(b), "R2 freq code", fcode_o, b);
      end
    end

    // equal level request is a no-op
    move(7);
    pulse(7);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!busy_o && !cpu_stall_o, "R9 no busy or stall", {busy_o, cpu_stall_o}, 0);
    end
    chk(vcode_o == 14 && fcode_o == 7, "R9 codes unchanged", vcode_o, 14);

    // requests during a transition: newest held, served after
    move(0);
    pulse(15);
    repeat (3) @(negedge clk);
    chk(busy_o, "R10 busy during ramp", busy_o, 1);
    pulse(3);
    pulse(7);
    while (busy_o) @(negedge clk);
    chk(level_o == 15, "R8 running move completes", level_o, 15);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chk(level_o == 7, "R8 newest request served", level_o, 7);
    chk(vcode_o == 14 && fcode_o == 7, "R8 codes", vcode_o, 14);

    // regulator never settles
    move(5);
    reg_stuck = 1'b1;
    move(9);
    chk(error_o, "R7 error on settle timeout", error_o, 1);
    chk(vcode_o == 10 && fcode_o == 5, "R7 codes reverted", vcode_o, 10);
    chk(level_o == 5 && !cpu_stall_o, "R7 level kept", level_o, 5);
    reg_stuck = 1'b0;
    repeat (8) @(negedge clk);

    // synthesizer never relocks
    pll_stuck = 1'b1;
    move(2);
    chk(fcode_o == 5 && vcode_o == 10, "R7 freq reverted", fcode_o, 5);
    chk(!cpu_stall_o && !busy_o, "R7 stall released", cpu_stall_o, 0);
    chk(error_o && level_o == 5, "R7 error sticky", error_o, 1);
    pll_stuck = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule